// File: doc/BRIEF.md
# Dual-Bank Indexed Register/RAM Port

This block sits between a narrow host bus and two banks of 128 byte locations. Each bank is reached through a pair of bus addresses: the host first stores a location number in the bank's pointer (index) register, then moves a byte to or from that location through the bank's data port. The extended bank is plain storage.

The standard bank mixes two kinds of location in one address space. Its lowest locations are not stored here at all. Accesses to them are forwarded to a set of live clock, alarm and control registers outside the block, through a select/strobe interface. A small number of further locations are also forwarded. Which locations these are is set by programmable pointer values supplied from outside. Everything else in the standard bank is general-purpose storage.

Each bank can be locked on its own. While a bank is locked, its data port returns a fixed fill value and drops writes, but its pointer register stays usable.

Top module: `dual_bank_port`

## Requirements
- R1: The two-bit bus address selects the port: 0 is the standard pointer, 1 the standard data port, 2 the extended pointer and 3 the extended data port.
- R2: Each pointer register keeps 7 bits. Bit 7 of a written byte is dropped. Reading a pointer returns the kept value with bit 7 clear. Both pointers are 0 after reset.
- R3: A standard data access at a location below 14 goes to the external register whose select equals the location. `creg_wr` or `creg_rd` is high in the same cycle as the bus strobe, and `creg_wdata` carries the bus byte.
- R4: A standard location of 14 or above that equals overlay pointer k (field k is `ovl_ptr[7k+6:7k]`) is forwarded with select 14+k. The lowest k wins when pointers coincide. A pointer value below 14 never takes a fixed location away from its register.
- R5: Every other standard location is storage: a byte written there is read back unchanged.
- R6: The extended bank has 128 locations of its own, independent of the standard bank. Its accesses never raise `creg_wr` or `creg_rd`.
- R7: While a bank's lock input is high, a read of its data port returns 0xFF, and a write there changes no storage and raises no external strobe. Pointer accesses are not affected by the lock.
- R8: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next accepted read. `bus_rdata` is 0 after reset.
- R9: When `bus_wr` and `bus_rd` are both high, the write is performed and the read is ignored, so `bus_rdata` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Port select (R1) |
| bus_wr | input | 1 | Write strobe, one cycle per transfer |
| bus_rd | input | 1 | Read strobe, one cycle per transfer |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| std_lock | input | 1 | Lock for the standard bank data port |
| ext_lock | input | 1 | Lock for the extended bank data port |
| ovl_ptr | input | 21 | Three 7-bit overlay pointers, pointer k in bits 7k+6:7k |
| creg_sel | output | 5 | Select of the forwarded register (0..16) |
| creg_wr | output | 1 | Write strobe to the forwarded register |
| creg_rd | output | 1 | Read strobe to the forwarded register |
| creg_wdata | output | 8 | Write byte to the forwarded register |
| creg_rdata | input | 8 | Read byte from the forwarded register, sampled during `creg_rd` |

## Verification
The hardest case to reach from the ports is an overlap between pointer routing and storage. A location that later becomes an overlay target may still hold a RAM byte, and two pointers may name the same location. The stimulus writes storage first and then moves the pointers onto those locations, including two coinciding pointers. It then checks that the forward strobes fire with the lowest-numbered select and that the stored byte becomes visible again once the pointers move away. The lock is handled the same way: a locked write is aimed at a location that already holds known data, and the bank is unlocked before the read-back.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

   typedef enum logic [1:0] {
      PORT_STD_IDX = 2'd0,
      PORT_STD_DAT = 2'd1,
      PORT_EXT_IDX = 2'd2,
      PORT_EXT_DAT = 2'd3
   } port_e;

   typedef enum logic [1:0] {
      RT_PTR  = 2'd0,
      RT_RAM  = 2'd1,
      RT_CREG = 2'd2,
      RT_FILL = 2'd3
   } route_e;

   localparam int unsigned N_BANKS = 2;

endpackage

// File: rtl/dbp_index_reg.sv
module dbp_index_reg #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic [IDX_W-1:0]  idx
);

   if (IDX_W >= DATA_W) begin : g_bad_width
      $error("dbp_index_reg: IDX_W must be narrower than DATA_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (load) begin
         idx <= load_data[IDX_W-1:0];
      end
   end

endmodule

// File: rtl/dbp_overlay_dec.sv
module dbp_overlay_dec #(
   parameter int unsigned IDX_W      = 7,
   parameter int unsigned FIXED_REGS = 14,
   parameter int unsigned N_PTR      = 3,
   parameter int unsigned SEL_W      = 5
) (
   input  logic [IDX_W-1:0]       idx,
   input  logic [N_PTR*IDX_W-1:0] ptrs,
   output logic                   hit,
   output logic [SEL_W-1:0]       sel
);

   localparam int unsigned N_SEL = FIXED_REGS + N_PTR;

   if (FIXED_REGS >= (1 << IDX_W)) begin : g_bad_fixed
      $error("dbp_overlay_dec: fixed region exceeds the bank");
   end
   if (N_SEL > (1 << SEL_W)) begin : g_bad_sel
      $error("dbp_overlay_dec: SEL_W too small for all forwarded registers");
   end

   logic             fixed_hit;
   logic [N_PTR-1:0] ptr_match;

   assign fixed_hit = (idx < IDX_W'(FIXED_REGS));

   for (genvar k = 0; k < N_PTR; k++) begin : g_ptr
      logic [IDX_W-1:0] ptr_k;
      assign ptr_k        = ptrs[k*IDX_W +: IDX_W];
      assign ptr_match[k] = !fixed_hit && (ptr_k == idx);
   end

   always_comb begin
      sel = SEL_W'(idx);
      if (!fixed_hit) begin
         sel = '0;
         for (int k = N_PTR - 1; k >= 0; k--) begin
            if (ptr_match[k]) begin
               sel = SEL_W'(FIXED_REGS + k);
            end
         end
      end
   end

   assign hit = fixed_hit || (|ptr_match);

endmodule

// File: rtl/dbp_ram.sv
module dbp_ram #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned AW     = 7
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << AW;

   if (DEPTH > 4096) begin : g_bad_depth
      $error("dbp_ram: depth too large for this macro");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/dual_bank_port.sv
module dual_bank_port
   import dbp_pkg::*;
#(
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       IDX_W      = 7,
   parameter int unsigned       FIXED_REGS = 14,
   parameter int unsigned       N_PTR      = 3,
   parameter logic [DATA_W-1:0] LOCK_FILL  = 8'hFF,
   parameter int unsigned       SEL_W      = $clog2(FIXED_REGS + N_PTR)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             bus_addr,
   input  logic                   bus_wr,
   input  logic                   bus_rd,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   input  logic                   std_lock,
   input  logic                   ext_lock,
   input  logic [N_PTR*IDX_W-1:0] ovl_ptr,
   output logic [SEL_W-1:0]       creg_sel,
   output logic                   creg_wr,
   output logic                   creg_rd,
   output logic [DATA_W-1:0]      creg_wdata,
   input  logic [DATA_W-1:0]      creg_rdata
);

   if (N_PTR == 0) begin : g_bad_ptr
      $error("dual_bank_port: at least one overlay pointer is required");
   end
   if (SEL_W < $clog2(FIXED_REGS + N_PTR)) begin : g_bad_sel
      $error("dual_bank_port: SEL_W too narrow");
   end

   port_e                    port;
   logic                     rd_acc;
   logic [N_BANKS-1:0]       lock_v;
   logic [N_BANKS-1:0]       idx_load;
   logic [N_BANKS-1:0]       dat_sel;
   logic [N_BANKS-1:0]       ram_we;
   logic [IDX_W-1:0]         idx_v   [N_BANKS];
   logic [DATA_W-1:0]        ram_q   [N_BANKS];
   logic                     ovl_hit;
   logic [SEL_W-1:0]         ovl_sel;
   logic                     std_fwd;
   route_e                   route;
   logic                     rd_bank;
   logic [DATA_W-1:0]        rdata_nxt;

   assign port   = port_e'(bus_addr);
   assign rd_acc = bus_rd && !bus_wr;
   assign lock_v = {ext_lock, std_lock};

   for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      assign idx_load[b] = bus_wr && (bus_addr == {b[0], 1'b0});
      assign dat_sel[b]  = (bus_addr == {b[0], 1'b1});

      dbp_index_reg #(
         .DATA_W (DATA_W),
         .IDX_W  (IDX_W)
      ) u_idx (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (idx_load[b]),
         .load_data (bus_wdata),
         .idx       (idx_v[b])
      );

      if (b == 0) begin : g_std_we
         assign ram_we[b] = bus_wr && dat_sel[b] && !lock_v[b] && !ovl_hit;
      end else begin : g_ext_we
         assign ram_we[b] = bus_wr && dat_sel[b] && !lock_v[b];
      end

      dbp_ram #(
         .DATA_W (DATA_W),
         .AW     (IDX_W)
      ) u_ram (
         .clk   (clk),
         .we    (ram_we[b]),
         .addr  (idx_v[b]),
         .wdata (bus_wdata),
         .rdata (ram_q[b])
      );
   end

   dbp_overlay_dec #(
      .IDX_W      (IDX_W),
      .FIXED_REGS (FIXED_REGS),
      .N_PTR      (N_PTR),
      .SEL_W      (SEL_W)
   ) u_dec (
      .idx  (idx_v[0]),
      .ptrs (ovl_ptr),
      .hit  (ovl_hit),
      .sel  (ovl_sel)
   );

   assign std_fwd    = dat_sel[0] && !std_lock && ovl_hit;
   assign creg_sel   = ovl_sel;
   assign creg_wdata = bus_wdata;
   assign creg_wr    = bus_wr && std_fwd;
   assign creg_rd    = rd_acc && std_fwd;

   always_comb begin
      rd_bank = bus_addr[1];
      route   = RT_PTR;
      case (port)
         PORT_STD_IDX, PORT_EXT_IDX: route = RT_PTR;
         PORT_STD_DAT: begin
            if (std_lock)     route = RT_FILL;
            else if (ovl_hit) route = RT_CREG;
            else              route = RT_RAM;
         end
         PORT_EXT_DAT: begin
            if (ext_lock) route = RT_FILL;
            else          route = RT_RAM;
         end
         default: route = RT_PTR;
      endcase
   end

   always_comb begin
      case (route)
         RT_PTR:  rdata_nxt = DATA_W'(idx_v[rd_bank]);
         RT_RAM:  rdata_nxt = ram_q[rd_bank];
         RT_CREG: rdata_nxt = creg_rdata;
         default: rdata_nxt = LOCK_FILL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_acc) begin
         bus_rdata <= rdata_nxt;
      end
   end

endmodule

// File: rtl/dbp_checker.sv
module dbp_checker #(
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       FIXED_REGS = 14,
   parameter int unsigned       N_PTR      = 3,
   parameter logic [DATA_W-1:0] LOCK_FILL  = 8'hFF,
   parameter int unsigned       SEL_W      = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              std_lock,
   input logic              ext_lock,
   input logic [SEL_W-1:0]  creg_sel,
   input logic              creg_wr,
   input logic              creg_rd,
   input logic [DATA_W-1:0] creg_wdata
);

   // R7: a locked standard data read yields the fill value
   p_lock_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == 2'd1 && std_lock) |=> (bus_rdata == LOCK_FILL));

   // R7: an extended-bank locked read yields the fill value
   p_ext_lock_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == 2'd3 && ext_lock) |=> (bus_rdata == LOCK_FILL));

   // R7: no forwarded strobe while the standard bank is locked
   p_no_strobe_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      std_lock |-> !(creg_wr || creg_rd));

   // R6: extended or pointer ports never reach the forwarded registers
   p_only_std_data_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (creg_wr || creg_rd) |-> (bus_addr == 2'd1));

   // R3: forwarded write carries the bus byte
   p_fwd_wdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
      creg_wr |-> (bus_wr && creg_wdata == bus_wdata));

   // R4: select stays inside the forwarded register range
   p_sel_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (creg_wr || creg_rd) |-> (creg_sel < SEL_W'(FIXED_REGS + N_PTR)));

   // R2: a pointer read never shows bit 7
   p_ptr_msb_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && !bus_addr[0]) |=> (bus_rdata[DATA_W-1] == 1'b0));

   // R8: read data holds when no read is accepted
   p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && !bus_wr) |=> $stable(bus_rdata));

   // R9: a combined strobe never raises the forwarded read
   p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> !creg_rd);

endmodule

bind dual_bank_port dbp_checker #(
   .DATA_W     (DATA_W),
   .FIXED_REGS (FIXED_REGS),
   .N_PTR      (N_PTR),
   .LOCK_FILL  (LOCK_FILL),
   .SEL_W      (SEL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .std_lock   (std_lock),
   .ext_lock   (ext_lock),
   .creg_sel   (creg_sel),
   .creg_wr    (creg_wr),
   .creg_rd    (creg_rd),
   .creg_wdata (creg_wdata)
);

// File: tb/dual_bank_port_bench.sv
`timescale 1ns/1ps
module dual_bank_port_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        std_lock = 1'b0;
   logic        ext_lock = 1'b0;
   logic [20:0] ovl_ptr = '0;
   logic [4:0]  creg_sel;
   logic        creg_wr;
   logic        creg_rd;
   logic [7:0]  creg_wdata;
   logic [7:0]  creg_rdata;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   // external register model: value identifies the select
   assign creg_rdata = {3'b101, creg_sel};

   dual_bank_port u_dual_bank_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .std_lock   (std_lock),
      .ext_lock   (ext_lock),
      .ovl_ptr    (ovl_ptr),
      .creg_sel   (creg_sel),
      .creg_wr    (creg_wr),
      .creg_rd    (creg_rd),
      .creg_wdata (creg_wdata),
      .creg_rdata (creg_rdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // write; checks forwarded strobe and select at the strobe cycle
   task automatic bus_write(input logic [1:0] a, input logic [7:0] d,
                            input bit exp_fwd, input logic [4:0] exp_sel, input string tag);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      #1;
      check({tag, " fwd strobe"}, {31'b0, creg_wr}, {31'b0, exp_fwd});
      if (exp_fwd) begin
         check({tag, " sel"}, {27'b0, creg_sel}, {27'b0, exp_sel});
         check({tag, " wdata"}, {24'b0, creg_wdata}, {24'b0, d});
      end
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // read; expected byte goes to the scoreboard
   task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // monitor: compares the read byte one cycle after each accepted read
   initial begin
      forever begin
         bit fire;
         @(posedge clk);
         fire = bus_rd && !bus_wr;
         @(negedge clk);
         if (fire) begin
            if (exp_q.size() == 0) begin
               check("R8 unexpected read result", 32'd1, 32'd0);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, {24'b0, bus_rdata}, {24'b0, e});
            end
         end
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         check("watchdog expired", 32'd1, 32'd0);
         finish_run();
      end
   end

   initial begin
      ovl_ptr = {7'h7E, 7'h41, 7'h40};
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 reset rdata", {24'b0, bus_rdata}, 32'd0);
      check("R3 reset strobes", {30'b0, creg_wr, creg_rd}, 32'd0);
      rst_n = 1'b1;

      // R2 pointers reset to 0; R1 pointer ports
      bus_read(2'd0, 8'h00, "R2 std pointer reset");
      bus_read(2'd2, 8'h00, "R2 ext pointer reset");

      // R2 bit 7 dropped
      bus_write(2'd0, 8'hA0, 1'b0, '0, "R2 std pointer load");
      bus_read(2'd0, 8'h20, "R2 std pointer readback");
      bus_write(2'd2, 8'hFF, 1'b0, '0, "R2 ext pointer load");
      bus_read(2'd2, 8'h7F, "R2 ext pointer readback");

      // R5 standard storage
      bus_write(2'd1, 8'h33, 1'b0, '0, "R5 std ram write");
      bus_read(2'd1, 8'h33, "R5 std ram read");
      bus_write(2'd0, 8'h41, 1'b0, '0, "R5 pointer to 0x41");
      ovl_ptr = {7'h7E, 7'h10, 7'h40};          // move pointer 1 away
      bus_write(2'd1, 8'hC4, 1'b0, '0, "R5 ram at 0x41");
      bus_read(2'd1, 8'hC4, "R5 ram at 0x41 read");

      // R6 extended bank independent
      bus_write(2'd2, 8'h20, 1'b0, '0, "R6 ext pointer 0x20");
      bus_write(2'd3, 8'h5A, 1'b0, '0, "R6 ext write");
      bus_read(2'd3, 8'h5A, "R6 ext read");
      bus_write(2'd0, 8'h20, 1'b0, '0, "R6 std pointer 0x20");
      bus_read(2'd1, 8'h33, "R6 std untouched by ext");
      bus_write(2'd2, 8'h05, 1'b0, '0, "R6 ext pointer 0x05");
      bus_write(2'd3, 8'h6B, 1'b0, '0, "R6 ext low loc no fwd");
      bus_read(2'd3, 8'h6B, "R6 ext low loc read");

      // R3 fixed registers
      for (int i = 0; i < 14; i += 13) begin
         bus_write(2'd0, 8'(i), 1'b0, '0, "R3 pointer to fixed");
         bus_write(2'd1, 8'h90, 1'b1, 5'(i), "R3 fixed write");
         bus_read(2'd1, {3'b101, 5'(i)}, "R3 fixed read");
      end
      bus_write(2'd0, 8'd14, 1'b0, '0, "R3 pointer to 14");
      bus_write(2'd1, 8'h4E, 1'b0, '0, "R3 loc 14 is ram");
      bus_read(2'd1, 8'h4E, "R3 loc 14 read");

      // R4 overlay pointers
      bus_write(2'd0, 8'h7E, 1'b0, '0, "R4 pointer 0x7E");
      bus_write(2'd1, 8'h12, 1'b1, 5'd16, "R4 ptr2 write");
      bus_read(2'd1, {3'b101, 5'd16}, "R4 ptr2 read");
      bus_write(2'd0, 8'h41, 1'b0, '0, "R4 pointer 0x41");
      ovl_ptr = {7'h7E, 7'h41, 7'h41};          // coinciding pointers
      bus_write(2'd1, 8'h21, 1'b1, 5'd14, "R4 priority ptr0 wins");
      bus_read(2'd1, {3'b101, 5'd14}, "R4 priority read");
      ovl_ptr = {7'h7E, 7'h41, 7'h40};
      bus_write(2'd1, 8'h22, 1'b1, 5'd15, "R4 ptr1 write");
      ovl_ptr = {7'h7E, 7'h10, 7'h40};          // move away: ram reappears
      bus_read(2'd1, 8'hC4, "R4 ram hidden then visible");
      ovl_ptr = {7'h05, 7'h10, 7'h40};          // low pointer: fixed wins
      bus_write(2'd0, 8'h05, 1'b0, '0, "R4 pointer 5");
      bus_write(2'd1, 8'h01, 1'b1, 5'd5, "R4 low pointer ignored");

      // R7 lock
      bus_write(2'd0, 8'h20, 1'b0, '0, "R7 std pointer 0x20");
      std_lock = 1'b1;
      bus_read(2'd1, 8'hFF, "R7 locked read");
      bus_write(2'd1, 8'h99, 1'b0, '0, "R7 locked write");
      bus_write(2'd0, 8'h03, 1'b0, '0, "R7 pointer load while locked");
      bus_read(2'd0, 8'h03, "R7 pointer read while locked");
      bus_write(2'd1, 8'h77, 1'b0, '0, "R7 locked fixed write no fwd");
      bus_write(2'd0, 8'h20, 1'b0, '0, "R7 pointer back");
      std_lock = 1'b0;
      bus_read(2'd1, 8'h33, "R7 data unchanged after lock");
      ext_lock = 1'b1;
      bus_write(2'd3, 8'hEE, 1'b0, '0, "R7 ext locked write");
      bus_read(2'd3, 8'hFF, "R7 ext locked read");
      ext_lock = 1'b0;
      bus_read(2'd3, 8'h6B, "R7 ext unchanged");

      // R8 hold
      repeat (4) @(negedge clk);
      check("R8 rdata holds", {24'b0, bus_rdata}, 32'h6B);

      // R9 write wins over read
      @(negedge clk);
      bus_addr = 2'd1; bus_wdata = 8'h77; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      check("R9 combined strobe no read", {24'b0, bus_rdata}, 32'h6B);
      bus_read(2'd1, 8'h77, "R9 write performed");

      repeat (3) @(negedge clk);
      check("R8 scoreboard drained", exp_q.size(), 32'd0);
      done = 1'b1;
      finish_run();
   end

endmodule